// File: doc/BRIEF.md
# Flash-Controller Register Port over I2C

This block is the host-facing register port of a LED flash and torch controller. A host on an I2C bus reads and writes six 8-bit configuration registers through it. The block oversamples SCL and SDA on the fast system clock, recognises its own slave address, and keeps a register pointer that steps forward after each byte. A write sets the pointer and then stores one or more data bytes. A read sets the pointer, issues a repeated START, and streams bytes out until the host sends a NACK. SDA is never driven high. The block only pulls it low through an output-enable.

The block also holds the status register. Event inputs from the analog and protection logic set its bits, and the bits stay set until the host reads them. While any status bit is set, an active-low attention line is pulled low. The line tells the host that there is news without the host having to poll. Two strap pins pick one of four slave addresses, and they are captured only during reset. While the power-enable bit is clear, every read returns zero. While the supply is reported low, the slave acknowledges nothing.

Top module: `ledctl_i2c_regs`

## Requirements
- R1: The slave address is 7'b01100 followed by the two strap bits. The strap bits are captured while reset is asserted and held afterwards. Strap code 00 means the address pin is tied to ground, 01 to the supply, 10 to SDA and 11 to SCL. Any other address byte gets no ACK.
- R2: A write is START, the address with bit0=0, a pointer byte, one or more data bytes, then STOP, and the slave ACKs every byte. Each data byte goes to the register at the pointer, and the pointer then increments by one.
- R3: A read uses the pointer already set, after a repeated START and the address with bit0=1. Each byte is sent MSB first. A host ACK moves to the next register, and a host NACK ends the read with SDA released.
- R4: The register indices are 0 command, 1 flash, 2 auxiliary LED, 3 status, 4 feature and 5 torch. All registers reset to 0x00. The five writable registers appear on their own output ports.
- R5: While command bit 7 (power enable) is 0, every read returns 0x00. The stored values and the output ports keep their contents.
- R6: Status bits are sticky and are set by evt_i[6:0] onto status bits 6..0, in this order: bit6 flash running, bit5 flash ready, bit4 LED temperature warning, bit3 LED too hot, bit2 chip overtemperature, bit1 light-sensor stop, bit0 charger thermal limit. Status bit 7 always reads 0. atn_n_o is low whenever any status bit is set.
- R7: When the last bit of a status byte has been shifted out with power enable set, the status register clears to 0x00 and atn_n_o goes high. A status read while powered down returns 0x00 and clears nothing.
- R8: Writes to index 3 or to any index above 5 are ACKed but change nothing. Reads of any index above 5 return 0x00.
- R9: While low_supply_i is 1, the slave ACKs no byte, commits no write and drops back to idle.
- R10: sda_oe_o changes only while SCL is low. The line is only pulled low, never driven high.
- R11: A STOP returns the slave to idle with SDA released. A START in any state restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap code, captured during reset |
| low_supply_i | input | 1 | Supply-too-low indication, suppresses ACK |
| evt_i | input | 7 | Status event inputs, one per status bit 6..0 |
| atn_n_o | output | 1 | Attention, active low (open-drain level) |
| cmd_o | output | 8 | Command register |
| flash_o | output | 8 | Flash register |
| aux_o | output | 8 | Auxiliary LED register |
| feat_o | output | 8 | Feature register |
| torch_o | output | 8 | Torch register |

## Verification
A wrong pointer shows up as the wrong byte in the next burst read, or as a write landing in the wrong output port, within one byte time. A stuck or early status clear shows up on atn_n_o, which must stay low until the status byte has been shifted out while powered. It must rise within a few clocks after that and never on a powered-down read. A bit-state error shows up as a missing or misplaced ACK on the very next ninth clock, or as SDA moving while SCL is high.

// File: rtl/ledctl_i2c_pkg.sv
// Package: shared constants and the protocol state type for the register port.
// Assumes: six 8-bit registers, status at a fixed index, power bit in command.
package ledctl_i2c_pkg;
    localparam int REG_COUNT  = 6;
    localparam int STATUS_IDX = 3;
    localparam int CMD_IDX    = 0;
    localparam int PWR_BIT    = 7;
    localparam int EVT_W      = 7;
    localparam int IDX_W      = $clog2(REG_COUNT);
    localparam logic [4:0] DEV_ADDR_HI = 5'b01100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RD_ACK
    } i2c_state_e;
endpackage

// File: rtl/ledctl_line_sync.sv
// Module: synchronises bus lines into the clock domain and flags their edges.
// Assumes: lines idle high; outputs lag the pads by STAGES clocks.
module ledctl_line_sync #(
    parameter int NUM_LINES = 2,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    output logic [NUM_LINES-1:0] level_o,
    output logic [NUM_LINES-1:0] rise_o,
    output logic [NUM_LINES-1:0] fall_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;

        // Shift the pad level through the synchroniser plus one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], line_i[g]};
        end

        assign level_o[g] = pipe_q[STAGES-1];
        assign rise_o[g]  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g]  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
    end
endmodule

// File: rtl/ledctl_i2c_fsm.sv
// Module: bit-level I2C slave engine with auto-incrementing register pointer.
// Assumes: synchronised SCL/SDA with edge flags; SCL low phase lasts several
// clocks; no clock stretching, 7-bit addressing only.
module ledctl_i2c_fsm
    import ledctl_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] addr_lo_i,
    input  logic       low_supply_i,
    input  logic [7:0] rd_byte_i,
    output logic       sda_oe_o,
    output logic [7:0] ptr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       rd_done_o
);
    i2c_state_e state_q;
    logic [7:0] shreg_q;
    logic [3:0] bit_cnt_q;
    logic       rw_q;
    logic       mack_q;
    logic       start_det, stop_det, byte_end;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign byte_end  = scl_fall & (bit_cnt_q == 4'd8);

    // Protocol sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe_o  <= 1'b0;
            ptr_o     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            rd_done_o <= 1'b0;
        end else begin
            wr_en_o   <= 1'b0;
            rd_done_o <= 1'b0;
            if (start_det) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                sda_oe_o  <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[6:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (byte_end) begin
                            bit_cnt_q <= '0;
                            if (low_supply_i) begin
                                state_q <= ST_IDLE;
                            end else if (state_q == ST_ADDR) begin
                                if (shreg_q[7:1] == {DEV_ADDR_HI, addr_lo_i}) begin
                                    rw_q     <= shreg_q[0];
                                    sda_oe_o <= 1'b1;
                                    state_q  <= ST_ACK_ADDR;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_o    <= shreg_q;
                                sda_oe_o <= 1'b1;
                                state_q  <= ST_ACK_PTR;
                            end else begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr_o;
                                wr_data_o <= shreg_q;
                                ptr_o     <= ptr_o + 8'd1;
                                sda_oe_o  <= 1'b1;
                                state_q   <= ST_ACK_WR;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q  <= rd_byte_i;
                                sda_oe_o <= ~rd_byte_i[7];
                                state_q  <= ST_RD;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state_q  <= ST_PTR;
                            end
                        end
                    end
                    ST_ACK_PTR, ST_ACK_WR: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            state_q  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (byte_end) begin
                            bit_cnt_q <= '0;
                            sda_oe_o  <= 1'b0;
                            rd_done_o <= 1'b1;
                            state_q   <= ST_RD_ACK;
                        end else if (scl_fall) begin
                            shreg_q  <= {shreg_q[6:0], 1'b0};
                            sda_oe_o <= ~shreg_q[6];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                            if (!sda_lvl) ptr_o <= ptr_o + 8'd1;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                shreg_q  <= rd_byte_i;
                                sda_oe_o <= ~rd_byte_i[7];
                                state_q  <= ST_RD;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) && !$past(start_det || stop_det) |-> !$past(scl_lvl)); // R10
    AST_NO_ACK_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_WR}) && (state_q != $past(state_q))
        |-> !$past(low_supply_i)); // R9
    AST_PTR_STEPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ptr_o == wr_addr_o + 8'd1); // R2
    AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !sda_oe_o); // R11
endmodule

// File: rtl/ledctl_regbank.sv
// Module: six-entry register bank with sticky status and power-gated reads.
// Assumes: one write strobe per byte from the protocol engine; status events
// are level inputs sampled every clock.
module ledctl_regbank
    import ledctl_i2c_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [7:0]                  wr_addr_i,
    input  logic [7:0]                  wr_data_i,
    input  logic [7:0]                  rd_addr_i,
    input  logic                        rd_done_i,
    input  logic [EVT_W-1:0]            evt_i,
    output logic [7:0]                  rd_byte_o,
    output logic [REG_COUNT-1:0][7:0]   regs_o,
    output logic                        atn_n_o
);
    localparam logic [REG_COUNT*8-1:0] CTRL_MASK =
        ~({{(REG_COUNT*8-8){1'b0}}, 8'hFF} << (8 * STATUS_IDX));

    logic [REG_COUNT-1:0][7:0] bank_q;
    logic                      pwr_on;
    logic                      st_clr;

    assign pwr_on = bank_q[CMD_IDX][PWR_BIT];
    assign st_clr = rd_done_i && (rd_addr_i == 8'(STATUS_IDX)) && pwr_on;

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        logic [7:0] q;
        if (i == STATUS_IDX) begin : g_status
            // Status: events set bits, a completed powered read clears them.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= (st_clr ? 8'h00 : q) | {{(8-EVT_W){1'b0}}, evt_i};
            end
        end else begin : g_ctrl
            // Control register: loaded by a host write aimed at its index.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    q <= '0;
                else if (wr_en_i && (wr_addr_i == 8'(i)))      q <= wr_data_i;
            end
        end
        assign bank_q[i] = q;
    end

    // Read mux: zero when powered down or past the end of the map.
    always_comb begin
        rd_byte_o = 8'h00;
        if (pwr_on && (rd_addr_i < 8'(REG_COUNT)))
            rd_byte_o = bank_q[rd_addr_i[IDX_W-1:0]];
    end

    assign regs_o  = bank_q;
    assign atn_n_o = ~(|bank_q[STATUS_IDX]);

    AST_RO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && ((wr_addr_i == 8'(STATUS_IDX)) || (wr_addr_i >= 8'(REG_COUNT)))
        |=> $stable(bank_q & CTRL_MASK)); // R8
    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_clr && (evt_i == '0) |=> (bank_q[STATUS_IDX] == 8'h00) && atn_n_o); // R7
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_clr |=> (($past(bank_q[STATUS_IDX]) & ~bank_q[STATUS_IDX]) == 8'h00)); // R6
endmodule

// File: rtl/ledctl_i2c_regs.sv
// Module: top of the I2C register port; ties synchroniser, protocol engine
// and register bank together and captures the address strap.
// Assumes: strap pins are stable while rst_n is low; pad logic turns
// sda_oe_o into an open-drain pull-down.
module ledctl_i2c_regs
    import ledctl_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [1:0]       strap_i,
    input  logic             low_supply_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic             atn_n_o,
    output logic [7:0]       cmd_o,
    output logic [7:0]       flash_o,
    output logic [7:0]       aux_o,
    output logic [7:0]       feat_o,
    output logic [7:0]       torch_o
);
    logic [1:0]                addr_lo_q;
    logic [1:0]                lvl, rise, fall;
    logic [7:0]                ptr, wr_addr, wr_data, rd_byte;
    logic                      wr_en, rd_done;
    logic [REG_COUNT-1:0][7:0] regs;

    // Capture the address strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_lo_q <= strap_i;
    end

    ledctl_line_sync #(.NUM_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  ({sda_i, scl_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    ledctl_i2c_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (lvl[0]),
        .scl_rise     (rise[0]),
        .scl_fall     (fall[0]),
        .sda_lvl      (lvl[1]),
        .sda_rise     (rise[1]),
        .sda_fall     (fall[1]),
        .addr_lo_i    (addr_lo_q),
        .low_supply_i (low_supply_i),
        .rd_byte_i    (rd_byte),
        .sda_oe_o     (sda_oe_o),
        .ptr_o        (ptr),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .rd_done_o    (rd_done)
    );

    ledctl_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (ptr),
        .rd_done_i (rd_done),
        .evt_i     (evt_i),
        .rd_byte_o (rd_byte),
        .regs_o    (regs),
        .atn_n_o   (atn_n_o)
    );

    assign cmd_o   = regs[0];
    assign flash_o = regs[1];
    assign aux_o   = regs[2];
    assign feat_o  = regs[4];
    assign torch_o = regs[5];

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(addr_lo_q)); // R1
endmodule

// File: tb/sim_ledctl_i2c_regs.sv
`timescale 1ns/1ps
module sim_ledctl_i2c_regs;
    localparam int Q = 8;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       low_sup = 1'b0;
    logic [6:0] evt = '0;
    logic       sda_oe, atn_n, bus_sda;
    logic [7:0] cmd, flash, aux, feat, torch;
    logic [7:0] rbuf [8];
    int         checks = 0, fails = 0, r10_viol = 0;
    bit         finished = 1'b0;
    item_t      exp_q[$], got_q[$];

    always #2.5 clk = ~clk;
    assign bus_sda = sda_m & ~sda_oe;

    ledctl_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe_o(sda_oe),
        .strap_i(strap), .low_supply_i(low_sup), .evt_i(evt), .atn_n_o(atn_n),
        .cmd_o(cmd), .flash_o(flash), .aux_o(aux), .feat_o(feat), .torch_o(torch)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: expected and observed items queued in pairs.
    task automatic post(input string tag, input logic [7:0] e, input logic [7:0] g);
        item_t a, b;
        a.tag = tag; a.val = e;
        b.tag = tag; b.val = g;
        exp_q.push_back(a);
        got_q.push_back(b);
    endtask

    // Monitor: pops pairs and compares them.
    initial forever begin
        @(negedge clk);
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            item_t e, g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            checks++;
            if (e.val !== g.val) begin
                fails++;
                $display("FAIL %s: got %h expected %h", e.tag, g.val, e.val);
            end
        end
    end

    // Watch for SDA pull-down changes while SCL is high.
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) r10_viol++;
        oe_prev <= sda_oe;
    end

    task automatic do_reset(input logic [1:0] s);
        strap = s; rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(5);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2); ack = ~bus_sda; tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q/2); b[i] = bus_sda; tick(Q/2); scl_m = 1'b0;
        end
        tick(2); sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write n bytes from a pointer; acks bit0=address, bit1=pointer, bit2+=data.
    task automatic i2c_write(input logic [6:0] dev, input logic [7:0] ptr,
                             input logic [7:0] d [4], input int n, output logic [5:0] acks);
        logic a;
        acks = '0;
        i2c_start();
        send_byte({dev, 1'b0}, a); acks[0] = a;
        if (a) begin
            send_byte(ptr, a); acks[1] = a;
            for (int k = 0; k < n; k++) begin
                send_byte(d[k], a); acks[2+k] = a;
            end
        end
        i2c_stop();
    endtask

    // Set pointer, repeated START, read n bytes into rbuf (NACK on last).
    task automatic i2c_read(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                            output logic [2:0] acks);
        logic a;
        logic [7:0] b;
        acks = '0;
        i2c_start();
        send_byte({dev, 1'b0}, a); acks[0] = a;
        send_byte(ptr, a); acks[1] = a;
        i2c_start();
        send_byte({dev, 1'b1}, a); acks[2] = a;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            rbuf[k] = b;
        end
        i2c_stop();
    endtask

    initial begin
        logic [5:0] wa;
        logic [2:0] ra;
        logic       a;
        logic [7:0] d [4];

        do_reset(2'b00);
        // R4 reset state
        post("R4 reset cmd", 8'h00, cmd);   post("R4 reset flash", 8'h00, flash);
        post("R4 reset aux", 8'h00, aux);   post("R4 reset feat", 8'h00, feat);
        post("R4 reset torch", 8'h00, torch);
        post("R6 reset atn_n", 8'h01, {7'd0, atn_n});
        post("R10 reset sda_oe", 8'h00, {7'd0, sda_oe});

        // R1 foreign address not acknowledged
        d = '{8'h5A, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h31, 8'h00, d, 1, wa);
        post("R1 foreign addr nack", 8'h00, {7'd0, wa[0]});
        post("R1 foreign write dropped", 8'h00, cmd);

        // R2 burst write from index 0
        d = '{8'h80, 8'h11, 8'h22, 8'h00};
        i2c_write(7'h30, 8'h00, d, 3, wa);
        post("R2 burst acks", 8'h1F, {3'd0, wa[4:0]});
        post("R2 cmd", 8'h80, cmd); post("R2 flash", 8'h11, flash); post("R2 aux", 8'h22, aux);
        d = '{8'h44, 8'h55, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h04, d, 2, wa);
        post("R2 feat", 8'h44, feat); post("R2 torch", 8'h55, torch);

        // R3 burst read of whole map
        i2c_read(7'h30, 8'h00, 6, ra);
        post("R3 read acks", 8'h07, {5'd0, ra});
        post("R3 idx0", 8'h80, rbuf[0]); post("R3 idx1", 8'h11, rbuf[1]);
        post("R3 idx2", 8'h22, rbuf[2]); post("R3 idx3", 8'h00, rbuf[3]);
        post("R3 idx4", 8'h44, rbuf[4]); post("R3 idx5", 8'h55, rbuf[5]);
        post("R11 released after stop", 8'h00, {7'd0, sda_oe});

        // R8 writes to read-only and out-of-map indices
        d = '{8'hFF, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h03, d, 1, wa);
        post("R8 status write acked", 8'h07, {5'd0, wa[2:0]});
        post("R8 atn unaffected", 8'h01, {7'd0, atn_n});
        d = '{8'h66, 8'h77, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h05, d, 2, wa);
        post("R8 crossing end acked", 8'h0F, {4'd0, wa[3:0]});
        post("R8 torch", 8'h66, torch);
        d = '{8'h99, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h07, d, 1, wa);
        post("R8 far write acked", 8'h07, {5'd0, wa[2:0]});
        i2c_read(7'h30, 8'h00, 6, ra);
        post("R8 cmd kept", 8'h80, rbuf[0]); post("R8 flash kept", 8'h11, rbuf[1]);
        post("R8 aux kept", 8'h22, rbuf[2]); post("R8 status kept", 8'h00, rbuf[3]);
        post("R8 feat kept", 8'h44, rbuf[4]);
        i2c_read(7'h30, 8'h06, 2, ra);
        post("R8 idx6 zero", 8'h00, rbuf[0]); post("R8 idx7 zero", 8'h00, rbuf[1]);

        // R6 sticky events and attention
        evt = 7'h41; tick(2); evt = 7'h00; tick(2);
        post("R6 atn low", 8'h00, {7'd0, atn_n});
        evt = 7'h04; tick(1); evt = 7'h00; tick(2);
        i2c_read(7'h30, 8'h03, 1, ra);
        post("R6 status bits", 8'h45, rbuf[0]);
        // R7 cleared by the read
        post("R7 atn released", 8'h01, {7'd0, atn_n});
        i2c_read(7'h30, 8'h03, 1, ra);
        post("R7 status now zero", 8'h00, rbuf[0]);

        // R5 powered-down reads and R7 no clear while powered down
        d = '{8'h00, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h00, d, 1, wa);
        post("R5 cmd cleared", 8'h00, cmd);
        i2c_read(7'h30, 8'h01, 1, ra);
        post("R5 read zero", 8'h00, rbuf[0]);
        post("R5 flash port kept", 8'h11, flash);
        evt = 7'h02; tick(1); evt = 7'h00; tick(2);
        i2c_read(7'h30, 8'h03, 1, ra);
        post("R5 status read zero", 8'h00, rbuf[0]);
        post("R7 atn held when off", 8'h00, {7'd0, atn_n});
        d = '{8'h80, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h00, d, 1, wa);
        i2c_read(7'h30, 8'h03, 1, ra);
        post("R7 status survives", 8'h02, rbuf[0]);
        post("R7 atn after powered read", 8'h01, {7'd0, atn_n});

        // R9 low supply suppresses ACK and writes
        low_sup = 1'b1;
        d = '{8'h12, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h05, d, 1, wa);
        post("R9 addr nack", 8'h00, {7'd0, wa[0]});
        low_sup = 1'b0;
        i2c_start();
        send_byte(8'h60, a); post("R9 addr ack ok", 8'h01, {7'd0, a});
        send_byte(8'h05, a);
        low_sup = 1'b1;
        send_byte(8'h34, a); post("R9 data nack", 8'h00, {7'd0, a});
        i2c_stop();
        low_sup = 1'b0;
        post("R9 torch unchanged", 8'h66, torch);
        d = '{8'h21, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h05, d, 1, wa);
        post("R9 recovery torch", 8'h21, torch);

        // R1 strap selections
        do_reset(2'b10);
        post("R4 reset after strap", 8'h00, torch);
        d = '{8'hAB, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h30, 8'h01, d, 1, wa);
        post("R1 strap10 old addr nack", 8'h00, {7'd0, wa[0]});
        i2c_write(7'h32, 8'h01, d, 1, wa);
        post("R1 strap10 ack", 8'h01, {7'd0, wa[0]});
        post("R1 strap10 flash", 8'hAB, flash);
        do_reset(2'b11);
        i2c_write(7'h32, 8'h01, d, 1, wa);
        post("R1 strap11 old nack", 8'h00, {7'd0, wa[0]});
        i2c_write(7'h33, 8'h01, d, 1, wa);
        post("R1 strap11 ack", 8'h01, {7'd0, wa[0]});
        do_reset(2'b01);
        i2c_write(7'h31, 8'h02, d, 1, wa);
        post("R1 strap01 aux", 8'hAB, aux);

        post("R10 sda moved with scl high", 8'h00, 8'(r10_viol));
        tick(4);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL WATCHDOG: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule